// File: doc/BRIEF.md
# Bridge FIFO Writer with Zero-Length Packet Closing

This block moves a word stream from on-chip logic into an external bridge chip that exposes a slave-FIFO write port. The port has a 32-bit data bus, a write strobe, an end-of-packet strobe, and two flow-control flags from the bridge. One flag means the current buffer has no room. The other means the buffer is nearly full. While words arrive, the block writes them back to back. When the bridge buffer fills, the bridge commits it by itself, and no end strobe is involved.

When the upstream source flags its last word, the block appends a fixed end-of-data marker word and raises the end strobe in the same cycle as that marker. The block keeps its own count of bytes in the bridge buffer. If the marker leaves the buffer holding a whole number of maximum-size packets, the host would keep waiting for more data. This includes the case where the marker completes the buffer exactly. In that case the block waits at least one idle cycle and until the buffer is no longer full. It then pulses the end strobe alone, which sends a zero-length packet.

Top module: `bridge_fifo_writer`

## Requirements
- R1: While reset is held, `dev_wr`, `dev_pktend` and `s_ready` are low. In the first cycle after reset is released, with both flags low, `s_ready` is high.
- R2: `dev_wr` is never high while `dev_full` is high. A buffer that reaches 16384 bytes is committed by the bridge with no end strobe from the block.
- R3: While `dev_partial` stays high, the block issues at most one write. `s_ready` stays low after that write until `dev_partial` falls.
- R4: After the upstream beat with `s_last` is written, the next write carries the word `MARK_WORD` (default 0xE0D0C0DE), with `dev_pktend` high in that same cycle.
- R5: If the bytes in the final buffer, counting the marker, are not a multiple of 1024, no zero-length packet follows.
- R6: If the final buffer holds a non-zero multiple of 1024 bytes below 16384, the block issues a zero-length packet: `dev_pktend` high with `dev_wr` low.
- R7: If the marker makes the buffer exactly 16384 bytes, a zero-length packet still follows.
- R8: The zero-length strobe comes at least two cycles after the marker strobe, with at least one idle cycle between them, and never while `dev_full` is high. With flags clear, it comes exactly two cycles after the marker.
- R9: `s_ready` is low while `dev_full` is high, during the marker cycle, and while a zero-length packet is pending.
- R10: The byte count advances by 4 per write and wraps at 16384. A 36864-byte stream, counting the marker, commits 16384, 16384, 4096 and then 0 bytes.
- R11: Data words reach `dev_data` in the order they were accepted, with no loss or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Upstream word valid |
| s_data | input | DATA_W | Upstream word |
| s_last | input | 1 | Marks the final upstream word of a stream |
| s_ready | output | 1 | Block accepts the upstream word this cycle |
| dev_full | input | 1 | Bridge buffer has no room |
| dev_partial | input | 1 | Bridge buffer nearly full: at most one more write |
| dev_wr | output | 1 | Write strobe to the bridge |
| dev_pktend | output | 1 | End-of-packet strobe to the bridge |
| dev_data | output | DATA_W | Word written to the bridge |

## Verification
The hardest case to reach is a marker that lands exactly on the 16384-byte boundary. There the bridge goes full in the same cycle the zero-length packet becomes pending, so the strobe must wait out the full period. The bench models the bridge: it commits a full buffer on its own and holds the full flag for three cycles. A 4096-word stream then drives the block into exactly this collision. The nearly-full flag normally lasts only one cycle, so the bench forces it high for several cycles while the source keeps offering words.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
   typedef enum logic [1:0] {
      SEQ_DATA = 2'd0,
      SEQ_MARK = 2'd1,
      SEQ_GAP  = 2'd2,
      SEQ_ZLP  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/bfw_byte_tracker.sv
module bfw_byte_tracker #(
   parameter int unsigned BUF_BYTES  = 16384,
   parameter int unsigned PKT_BYTES  = 1024,
   parameter int unsigned WORD_BYTES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_fire,
   input  logic end_fire,
   output logic at_pkt_edge
);
   localparam int unsigned CNT_W   = $clog2(BUF_BYTES);
   localparam int unsigned PKT_LOG = $clog2(PKT_BYTES);

   logic [CNT_W-1:0] fill_q;
   logic [CNT_W:0]   fill_sum;
   logic             wrap;

   assign fill_sum = {1'b0, fill_q} + (CNT_W+1)'(WORD_BYTES);
   assign wrap     = (fill_sum == (CNT_W+1)'(BUF_BYTES));

   generate
      if ((PKT_BYTES & (PKT_BYTES - 1)) == 0) begin : g_pow2
         assign at_pkt_edge = (fill_sum[PKT_LOG-1:0] == '0);
      end else begin : g_modulo
         assign at_pkt_edge = ((fill_sum % (CNT_W+1)'(PKT_BYTES)) == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         fill_q <= '0;
      else if (wr_fire)
         fill_q <= (end_fire || wrap) ? '0 : fill_sum[CNT_W-1:0];
   end

   AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !end_fire && !wrap) |=> (fill_q > $past(fill_q))); // R10
endmodule

// File: rtl/bfw_flow_gate.sv
module bfw_flow_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic dev_full,
   input  logic dev_partial,
   input  logic wr_fire,
   output logic wr_ok,
   output logic zlp_ok
);
   logic live_q;
   logic used_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         used_q <= 1'b0;
      end else begin
         live_q <= 1'b1;
         if (!dev_partial)
            used_q <= 1'b0;
         else if (wr_fire)
            used_q <= 1'b1;
      end
   end

   assign wr_ok  = live_q && !dev_full && !(dev_partial && used_q);
   assign zlp_ok = live_q && !dev_full;

   AST_PARTIAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_partial && $past(dev_partial) && $past(wr_fire)) |-> !wr_fire); // R3
endmodule

// File: rtl/bfw_seq.sv
module bfw_seq
   import bfw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic s_valid,
   input  logic s_last,
   input  logic wr_ok,
   input  logic zlp_ok,
   input  logic at_pkt_edge,
   output logic s_ready,
   output logic wr_fire,
   output logic end_fire,
   output logic mark_sel,
   output logic zlp_fire
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d  = state_q;
      s_ready  = 1'b0;
      wr_fire  = 1'b0;
      end_fire = 1'b0;
      mark_sel = 1'b0;
      zlp_fire = 1'b0;
      case (state_q)
         SEQ_DATA: begin
            s_ready = wr_ok;
            wr_fire = s_valid && wr_ok;
            if (wr_fire && s_last) state_d = SEQ_MARK;
         end
         SEQ_MARK: begin
            if (wr_ok) begin
               wr_fire  = 1'b1;
               end_fire = 1'b1;
               mark_sel = 1'b1;
               state_d  = at_pkt_edge ? SEQ_GAP : SEQ_DATA;
            end
         end
         SEQ_GAP: state_d = SEQ_ZLP;
         SEQ_ZLP: begin
            if (zlp_ok) begin
               zlp_fire = 1'b1;
               state_d  = SEQ_DATA;
            end
         end
         default: state_d = SEQ_DATA;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEQ_DATA;
      else        state_q <= state_d;
   end

   AST_LAST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && s_last && !mark_sel) |=> !s_ready); // R9
endmodule

// File: rtl/bridge_fifo_writer.sv
module bridge_fifo_writer #(
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          BUF_BYTES = 16384,
   parameter int unsigned          PKT_BYTES = 1024,
   parameter logic [DATA_W-1:0]    MARK_WORD = DATA_W'(32'hE0D0_C0DE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   input  logic              dev_full,
   input  logic              dev_partial,
   output logic              dev_wr,
   output logic              dev_pktend,
   output logic [DATA_W-1:0] dev_data
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (BUF_BYTES % PKT_BYTES != 0) begin : g_bad_buf
         $error("BUF_BYTES must be a multiple of PKT_BYTES");
      end
      if (PKT_BYTES % WORD_BYTES != 0 || PKT_BYTES < 2 * WORD_BYTES) begin : g_bad_pkt
         $error("PKT_BYTES must hold at least two words, evenly");
      end
   endgenerate

   logic wr_ok, zlp_ok, at_pkt_edge;
   logic wr_fire, end_fire, mark_sel, zlp_fire;

   bfw_flow_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_full    (dev_full),
      .dev_partial (dev_partial),
      .wr_fire     (wr_fire),
      .wr_ok       (wr_ok),
      .zlp_ok      (zlp_ok)
   );

   bfw_byte_tracker #(
      .BUF_BYTES  (BUF_BYTES),
      .PKT_BYTES  (PKT_BYTES),
      .WORD_BYTES (WORD_BYTES)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_fire     (wr_fire),
      .end_fire    (end_fire),
      .at_pkt_edge (at_pkt_edge)
   );

   bfw_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .s_valid     (s_valid),
      .s_last      (s_last),
      .wr_ok       (wr_ok),
      .zlp_ok      (zlp_ok),
      .at_pkt_edge (at_pkt_edge),
      .s_ready     (s_ready),
      .wr_fire     (wr_fire),
      .end_fire    (end_fire),
      .mark_sel    (mark_sel),
      .zlp_fire    (zlp_fire)
   );

   assign dev_wr     = wr_fire;
   assign dev_pktend = end_fire || zlp_fire;
   assign dev_data   = mark_sel ? MARK_WORD : s_data;

   AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      dev_wr |-> !dev_full); // R2
   AST_MARK_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_pktend && dev_wr) |-> (dev_data == MARK_WORD)); // R4
   AST_ZLP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_pktend && !dev_wr) |-> !$past(dev_pktend)); // R8
   AST_ZLP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_pktend && !dev_wr) |-> !dev_full); // R8
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !dev_full); // R9
endmodule

// File: tb/bridge_fifo_writer_tb.sv
module bridge_fifo_writer_tb;
   localparam int BUF   = 16384;
   localparam int PKT   = 1024;
   localparam int BUFW  = BUF / 4;
   localparam logic [31:0] MARK = 32'hE0D0_C0DE;

   localparam int NV = 7;
   // total words per stream (including marker), expected commit count, ZLP expected
   localparam int VEC_WORDS   [NV] = '{2, 10, 256, 512, 4096, 4097, 9216};
   localparam int VEC_NCOMMIT [NV] = '{1, 1,  2,   2,   2,    2,    4};
   localparam int VEC_ZLP     [NV] = '{0, 0,  1,   1,   1,    0,    1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s_valid = 1'b0, s_last = 1'b0;
   logic [31:0] s_data = '0;
   logic s_ready, dev_wr, dev_pktend;
   logic [31:0] dev_data;
   logic dev_full, dev_partial;
   logic force_partial = 1'b0;
   logic clr_log = 1'b0;

   int n_chk = 0, n_fail = 0;
   int seq = 1;

   // bridge model state
   int dcnt, busy, ncommit, wr_total, cyc, mark_cyc, zlp_cyc;
   int err_full, err_rdy, err_order, err_mark;
   logic [31:0] exp_word;
   int commit_sz [8];

   always #5 clk = ~clk;

   assign dev_full    = (busy != 0);
   assign dev_partial = force_partial || (busy == 0 && dcnt == BUFW - 1);

   bridge_fifo_writer u_dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
      .s_ready(s_ready), .dev_full(dev_full), .dev_partial(dev_partial),
      .dev_wr(dev_wr), .dev_pktend(dev_pktend), .dev_data(dev_data)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         dcnt <= 0; busy <= 0; ncommit <= 0; wr_total <= 0;
         err_full <= 0; err_rdy <= 0; err_order <= 0; err_mark <= 0;
         exp_word <= 32'd1; mark_cyc <= 0; zlp_cyc <= 0;
      end else begin
         if (busy != 0) busy <= busy - 1;
         if ((dev_wr || dev_pktend) && dev_full) err_full <= err_full + 1;
         if (s_ready && dev_full) err_rdy <= err_rdy + 1;
         if (dev_wr) wr_total <= wr_total + 1;
         if (dev_wr && !dev_pktend) begin
            if (dev_data != exp_word) err_order <= err_order + 1;
            exp_word <= exp_word + 1;
         end
         if (dev_wr && dev_pktend && dev_data != MARK) err_mark <= err_mark + 1;
         if (clr_log) ncommit <= 0;
         if (dev_pktend) begin
            if (!clr_log && ncommit < 8) commit_sz[ncommit] <= (dcnt + (dev_wr ? 1 : 0)) * 4;
            if (!clr_log) ncommit <= ncommit + 1;
            if (dev_wr && dcnt + 1 == BUFW) busy <= 3;
            dcnt <= 0;
            if (dev_wr) mark_cyc <= cyc; else zlp_cyc <= cyc;
         end else if (dev_wr) begin
            if (dcnt + 1 == BUFW) begin
               if (!clr_log && ncommit < 8) commit_sz[ncommit] <= BUF;
               if (!clr_log) ncommit <= ncommit + 1;
               dcnt <= 0; busy <= 3;
            end else dcnt <= dcnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive_beat(input logic [31:0] d, input bit last);
      s_valid = 1'b1; s_data = d; s_last = last;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic send_stream(input int n);
      for (int i = 0; i < n; i++) begin
         drive_beat(seq, i == n - 1);
         seq++;
      end
   endtask

   task automatic clear_log();
      clr_log = 1'b1;
      @(negedge clk);
      clr_log = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!dev_wr && !dev_pktend, "R1 strobes in reset", {dev_wr, dev_pktend}, 0);
      chk(!s_ready, "R1 ready in reset", s_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(s_ready, "R1 ready after reset", s_ready, 1);

      // table walk: R5 R6 R7 R10 R11 R4 R8
      for (int v = 0; v < NV; v++) begin
         int bytes, nfull, rem, idx;
         clear_log();
         send_stream(VEC_WORDS[v] - 1);
         repeat (14) @(negedge clk);
         bytes = VEC_WORDS[v] * 4;
         nfull = bytes / BUF;
         rem   = bytes % BUF;
         chk(ncommit == VEC_NCOMMIT[v], "R10 commit count", ncommit, VEC_NCOMMIT[v]);
         idx = 0;
         for (int k = 0; k < nfull && idx < 8; k++) begin
            chk(commit_sz[idx] == BUF, "R2 full commit size", commit_sz[idx], BUF);
            idx++;
         end
         if (rem != 0 && idx < 8) begin
            chk(commit_sz[idx] == rem, "R5 short commit size", commit_sz[idx], rem);
            idx++;
         end
         if (VEC_ZLP[v] != 0) begin
            chk(idx < 8 && ncommit > idx && commit_sz[idx] == 0, "R6 R7 zero-length packet",
                commit_sz[idx], 0);
            chk(zlp_cyc - mark_cyc >= 2, "R8 gap after marker", zlp_cyc - mark_cyc, 2);
         end else begin
            chk(ncommit == idx, "R5 no zero-length packet", ncommit, idx);
         end
      end

      // R9 / R8 exact timing of a ZLP with clear flags
      clear_log();
      send_stream(255);
      chk(!s_ready && dev_pktend && dev_wr, "R9 marker cycle blocks ready", s_ready, 0);
      @(negedge clk);
      chk(!s_ready && !dev_pktend, "R9 gap cycle idle", {s_ready, dev_pktend}, 0);
      @(negedge clk);
      chk(dev_pktend && !dev_wr && !s_ready, "R8 ZLP two cycles after marker",
          {dev_pktend, dev_wr, s_ready}, 3'b100);
      @(negedge clk);
      chk(s_ready, "R9 ready back after ZLP", s_ready, 1);

      // R3 nearly-full flag held high
      base = wr_total;
      force_partial = 1'b1;
      s_valid = 1'b1; s_data = seq; s_last = 1'b0;
      @(negedge clk);
      seq++; s_data = seq;
      repeat (4) @(negedge clk);
      chk(wr_total - base == 1, "R3 single write under partial", wr_total - base, 1);
      chk(!s_ready, "R3 ready held low under partial", s_ready, 0);
      force_partial = 1'b0;
      @(negedge clk);
      seq++;
      drive_beat(seq, 1'b1);
      seq++;
      repeat (6) @(negedge clk);
      chk(wr_total - base == 4, "R3 writes resume after partial", wr_total - base, 4);

      // whole-run monitors
      chk(err_full == 0, "R2 R8 strobe while full", err_full, 0);
      chk(err_rdy == 0, "R9 ready while full", err_rdy, 0);
      chk(err_order == 0, "R11 data order", err_order, 0);
      chk(err_mark == 0, "R4 marker word", err_mark, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule